// File: doc/BRIEF.md
# Register-Direct Integer Instruction Executor

This block runs a compact subset of 32-bit integer instructions whose operands are both registers. Instruction bytes arrive one per cycle over a valid/ready handshake. A small state machine takes the opcode byte, then the operand-selector byte when the encoding needs one, and executes in a single cycle. The result lands in an eight-entry 32-bit register file, and the sign, zero and overflow flags are updated according to the operation.

The supported operations are add, subtract, AND, OR, XOR, copy, exchange, compare, bitwise NOT, and increment and decrement. Increment and decrement come in a one-byte form, with the register number in the opcode, and in an operand-selector form. Any encoding outside this set stops the block for good. A sticky illegal flag is raised, and no further bytes are taken until reset. Other units read the register file through a combinational read port.

State machine: `ST_FETCH` (waiting for an opcode), `ST_MODRM` (waiting for the operand-selector byte), `ST_EXEC` (one execute cycle) and `ST_HALT` (stopped). The transitions are:
- fetch-to-modrm: a two-byte opcode is accepted.
- fetch-to-exec: a one-byte increment or decrement is accepted.
- fetch-to-halt: an unknown opcode is accepted.
- modrm-to-exec: a legal selector is accepted.
- modrm-to-halt: an illegal selector is accepted.
- exec-to-fetch: always, after the execute cycle.
- halt-to-halt: always, until reset.

Top module: `regx_exec`

## Requirements
- R1: After reset, all eight registers read 0, the flags are 0, `illegal` is 0 and `in_ready` is 1.
- R2: The selector byte is split into mode (bits 7:6), reg (bits 5:3) and rm (bits 2:0). Only mode 3 is legal. rm names the destination register, and reg names the source register or a sub-operation. Register numbers 0 to 7 select entries 0 to 7.
- R3: Opcode 0x01 sets rm = rm + reg, and opcode 0x29 sets rm = rm - reg. SF is result bit 31 and ZF means a zero result. OF is set on signed overflow.
- R4: Opcodes 0x21, 0x09 and 0x31 set rm to rm AND reg, rm OR reg and rm XOR reg. SF and ZF come from the result, and OF is cleared. For example, 0x0a0b0c0d XOR 0xaabbc0d0 gives 0xa0b0ccdd.
- R5: Opcode 0x89 copies reg into rm. Opcode 0x87 swaps reg and rm. Neither changes the flags.
- R6: Opcode 0x39 computes rm - reg and sets SF, ZF and OF as subtraction does, without writing any register.
- R7: Opcodes 0x40 to 0x47 increment, and 0x48 to 0x4F decrement, the register given by opcode bits 2:0. SF and ZF come from the result. OF is set for 0x7fffffff+1 and for 0x80000000-1.
- R8: Opcode 0xFF with reg field 0 increments rm, and with reg field 1 decrements rm. The flags follow the same rules as R7.
- R9: Opcode 0xF7 with reg field 2 replaces rm with its bitwise complement. SF is bit 31 and ZF means a zero result, and OF is cleared.
- R10: Each of these encodings sets a sticky `illegal` output:
  - any other opcode;
  - 0xFF with a reg field other than 0 or 1;
  - 0xF7 with a reg field other than 2;
  - a selector whose mode is not 3.
  From then on, `in_ready` stays low and no register or flag changes until reset.
- R11: Bytes are accepted in any cycle in which `in_ready` is high. The cycle after the last byte of an instruction has `in_ready` low. In the cycle after that, `retire` is high for one cycle, the results are visible, and `in_ready` is high again.
- R12: `rd_value` shows the register selected by `rd_sel` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction byte is valid |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Block takes a byte this cycle |
| rd_sel | input | 3 | Register read select |
| rd_value | output | XLEN | Selected register contents |
| flag_sf | output | 1 | Sign flag |
| flag_zf | output | 1 | Zero flag |
| flag_of | output | 1 | Overflow flag |
| retire | output | 1 | One-cycle pulse when an instruction's results are visible |
| illegal | output | 1 | Sticky unsupported-encoding indication |

## Verification
The hardest situations to reach are the signed-overflow boundaries, because the block has no immediate operands. Registers therefore start at zero, and a value such as 0x7fffffff or 0x80000000 can only be built from instructions. The bench builds any 32-bit value by clearing a register with XOR. It then doubles the register with add-to-self and uses a one-byte increment for each set bit. Every step of this sequence is itself checked against the bench model. Random operations then run on top of these values, and directed overflow, compare and illegal-encoding cases are built in the same way.

// File: rtl/regx_pkg.sv
package regx_pkg;
    localparam int unsigned NREG = 8;
    localparam int unsigned RIDX = $clog2(NREG);

    typedef enum logic [1:0] {
        ST_FETCH,
        ST_MODRM,
        ST_EXEC,
        ST_HALT
    } state_e;

    typedef enum logic [3:0] {
        OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR,
        OP_MOV, OP_XCHG, OP_CMP, OP_INC, OP_DEC,
        OP_NOT, OP_NONE
    } op_e;

    localparam logic [7:0] OPC_ADD  = 8'h01;
    localparam logic [7:0] OPC_SUB  = 8'h29;
    localparam logic [7:0] OPC_AND  = 8'h21;
    localparam logic [7:0] OPC_OR   = 8'h09;
    localparam logic [7:0] OPC_XOR  = 8'h31;
    localparam logic [7:0] OPC_MOV  = 8'h89;
    localparam logic [7:0] OPC_XCHG = 8'h87;
    localparam logic [7:0] OPC_CMP  = 8'h39;
    localparam logic [7:0] OPC_GRPU = 8'hFF;
    localparam logic [7:0] OPC_GRPN = 8'hF7;
    localparam logic [3:0] OPC_SHORT_HI = 4'h4;
endpackage

// File: rtl/regx_decode.sv
module regx_decode
    import regx_pkg::*;
(
    input  logic [7:0] opc,
    input  logic [7:0] modrm,
    output op_e        op,
    output logic       needs_modrm,
    output logic       opc_ok,
    output logic       modrm_ok
);
    always_comb begin
        op          = OP_NONE;
        needs_modrm = 1'b1;
        opc_ok      = 1'b1;
        case (opc)
            OPC_ADD:  op = OP_ADD;
            OPC_SUB:  op = OP_SUB;
            OPC_AND:  op = OP_AND;
            OPC_OR:   op = OP_OR;
            OPC_XOR:  op = OP_XOR;
            OPC_MOV:  op = OP_MOV;
            OPC_XCHG: op = OP_XCHG;
            OPC_CMP:  op = OP_CMP;
            OPC_GRPU: begin
                if (modrm[5:3] == 3'd0)      op = OP_INC;
                else if (modrm[5:3] == 3'd1) op = OP_DEC;
                else                         op = OP_NONE;
            end
            OPC_GRPN: op = (modrm[5:3] == 3'd2) ? OP_NOT : OP_NONE;
            default: begin
                if (opc[7:4] == OPC_SHORT_HI) begin
                    needs_modrm = 1'b0;
                    op          = opc[3] ? OP_DEC : OP_INC;
                end else begin
                    opc_ok = 1'b0;
                end
            end
        endcase
        modrm_ok = (modrm[7:6] == 2'b11) && (op != OP_NONE);
    end
endmodule

// File: rtl/regx_alu.sv
module regx_alu
    import regx_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  op_e          op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic         wr_a,
    output logic         wr_b,
    output logic         upd,
    output logic         ovf
);
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] sum, diff;
    assign sum  = a + b;
    assign diff = a - b;

    always_comb begin
        res  = '0;
        wr_a = 1'b0;
        wr_b = 1'b0;
        upd  = 1'b0;
        ovf  = 1'b0;
        case (op)
            OP_ADD: begin
                res = sum; wr_a = 1'b1; upd = 1'b1;
                ovf = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
            end
            OP_SUB: begin
                res = diff; wr_a = 1'b1; upd = 1'b1;
                ovf = (a[W-1] != b[W-1]) && (diff[W-1] != a[W-1]);
            end
            OP_CMP: begin
                res = diff; upd = 1'b1;
                ovf = (a[W-1] != b[W-1]) && (diff[W-1] != a[W-1]);
            end
            OP_AND:  begin res = a & b; wr_a = 1'b1; upd = 1'b1; end
            OP_OR:   begin res = a | b; wr_a = 1'b1; upd = 1'b1; end
            OP_XOR:  begin res = a ^ b; wr_a = 1'b1; upd = 1'b1; end
            OP_NOT:  begin res = ~a;    wr_a = 1'b1; upd = 1'b1; end
            OP_MOV:  begin res = b;     wr_a = 1'b1; end
            OP_XCHG: begin res = b;     wr_a = 1'b1; wr_b = 1'b1; end
            OP_INC: begin
                res = a + ONE; wr_a = 1'b1; upd = 1'b1;
                ovf = (a == SMAX);
            end
            OP_DEC: begin
                res = a - ONE; wr_a = 1'b1; upd = 1'b1;
                ovf = (a == SMIN);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/regx_regfile.sv
module regx_regfile
    import regx_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we0,
    input  logic [RIDX-1:0] wa0,
    input  logic [W-1:0]    wd0,
    input  logic            we1,
    input  logic [RIDX-1:0] wa1,
    input  logic [W-1:0]    wd1,
    input  logic [RIDX-1:0] ra0,
    input  logic [RIDX-1:0] ra1,
    input  logic [RIDX-1:0] ra2,
    output logic [W-1:0]    rd0,
    output logic [W-1:0]    rd1,
    output logic [W-1:0]    rd2
);
    logic [W-1:0] ent [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_ent
        logic [W-1:0] ent_q;
        always_ff @(posedge clk) begin
            if (!rst_n)                                ent_q <= '0;
            else if (we1 && (wa1 == RIDX'(i)))         ent_q <= wd1;
            else if (we0 && (wa0 == RIDX'(i)))         ent_q <= wd0;
        end
        assign ent[i] = ent_q;
    end

    assign rd0 = ent[ra0];
    assign rd1 = ent[ra1];
    assign rd2 = ent[ra2];
endmodule

// File: rtl/regx_exec.sv
module regx_exec
    import regx_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [7:0]      in_byte,
    output logic            in_ready,
    input  logic [RIDX-1:0] rd_sel,
    output logic [XLEN-1:0] rd_value,
    output logic            flag_sf,
    output logic            flag_zf,
    output logic            flag_of,
    output logic            retire,
    output logic            illegal
);
    state_e            state_q, state_d;
    logic [7:0]        opc_q;
    op_e               op_q;
    logic [RIDX-1:0]   dst_q, src_q;
    logic              sf_q, zf_q, of_q, retire_q, illegal_q;

    op_e               dec_op;
    logic              dec_needs, dec_opc_ok, dec_modrm_ok;
    logic              accept;
    logic [XLEN-1:0]   val_a, val_b, alu_res;
    logic              alu_wr_a, alu_wr_b, alu_upd, alu_ovf;

    assign in_ready = (state_q == ST_FETCH) || (state_q == ST_MODRM);
    assign accept   = in_valid && in_ready;

    regx_decode u_dec (
        .opc         ((state_q == ST_FETCH) ? in_byte : opc_q),
        .modrm       (in_byte),
        .op          (dec_op),
        .needs_modrm (dec_needs),
        .opc_ok      (dec_opc_ok),
        .modrm_ok    (dec_modrm_ok)
    );

    regx_alu #(.W(XLEN)) u_alu (
        .op   (op_q),
        .a    (val_a),
        .b    (val_b),
        .res  (alu_res),
        .wr_a (alu_wr_a),
        .wr_b (alu_wr_b),
        .upd  (alu_upd),
        .ovf  (alu_ovf)
    );

    regx_regfile #(.W(XLEN)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we0   ((state_q == ST_EXEC) && alu_wr_a),
        .wa0   (dst_q),
        .wd0   (alu_res),
        .we1   ((state_q == ST_EXEC) && alu_wr_b),
        .wa1   (src_q),
        .wd1   (val_a),
        .ra0   (dst_q),
        .ra1   (src_q),
        .ra2   (rd_sel),
        .rd0   (val_a),
        .rd1   (val_b),
        .rd2   (rd_value)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH: if (accept) begin
                if (!dec_opc_ok)     state_d = ST_HALT;   // fetch-to-halt
                else if (dec_needs)  state_d = ST_MODRM;  // fetch-to-modrm
                else                 state_d = ST_EXEC;   // fetch-to-exec
            end
            ST_MODRM: if (accept) begin
                state_d = dec_modrm_ok ? ST_EXEC : ST_HALT;
            end
            ST_EXEC:  state_d = ST_FETCH;                 // exec-to-fetch
            ST_HALT:  state_d = ST_HALT;                  // halt-to-halt
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FETCH;
        else        state_q <= state_d;
    end

    // captured instruction fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opc_q <= '0;
            op_q  <= OP_NONE;
            dst_q <= '0;
            src_q <= '0;
        end else if (accept && (state_q == ST_FETCH)) begin
            opc_q <= in_byte;
            op_q  <= dec_op;
            dst_q <= in_byte[RIDX-1:0];
            src_q <= in_byte[RIDX-1:0];
        end else if (accept && (state_q == ST_MODRM)) begin
            op_q  <= dec_op;
            dst_q <= in_byte[RIDX-1:0];
            src_q <= in_byte[2*RIDX-1:RIDX];
        end
    end

    // outputs: flags, retire pulse, sticky illegal
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sf_q      <= 1'b0;
            zf_q      <= 1'b0;
            of_q      <= 1'b0;
            retire_q  <= 1'b0;
            illegal_q <= 1'b0;
        end else begin
            retire_q  <= (state_q == ST_EXEC);
            illegal_q <= illegal_q | (state_d == ST_HALT);
            if ((state_q == ST_EXEC) && alu_upd) begin
                sf_q <= alu_res[XLEN-1];
                zf_q <= (alu_res == '0);
                of_q <= alu_ovf;
            end
        end
    end

    assign flag_sf = sf_q;
    assign flag_zf = zf_q;
    assign flag_of = of_q;
    assign retire  = retire_q;
    assign illegal = illegal_q;
endmodule

// File: rtl/regx_exec_chk.sv
module regx_exec_chk (
    input logic clk,
    input logic rst_n,
    input logic in_ready,
    input logic retire,
    input logic illegal,
    input logic sf,
    input logic zf,
    input logic of
);
    a_r10_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> illegal);

    a_r10_not_ready_halted: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !in_ready);

    a_r11_retire_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        retire |=> !retire);

    a_r11_ready_on_retire: assert property (@(posedge clk) disable iff (!rst_n)
        retire |-> in_ready);

    a_r11_flags_move_on_retire: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({sf, zf, of}) |-> retire);

    a_r3_zero_excludes_negative: assert property (@(posedge clk) disable iff (!rst_n)
        zf |-> !sf);
endmodule

bind regx_exec regx_exec_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_ready (in_ready),
    .retire   (retire),
    .illegal  (illegal),
    .sf       (flag_sf),
    .zf       (flag_zf),
    .of       (flag_of)
);

// File: tb/regx_exec_bench.sv
module regx_exec_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        in_ready;
    logic [2:0]  rd_sel = 3'd0;
    logic [31:0] rd_value;
    logic        flag_sf, flag_zf, flag_of, retire, illegal;

    always #4 clk = ~clk;   // 125 MHz

    regx_exec u_regx_exec (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .rd_sel(rd_sel), .rd_value(rd_value),
        .flag_sf(flag_sf), .flag_zf(flag_zf), .flag_of(flag_of),
        .retire(retire), .illegal(illegal)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [31:0] mreg [8];
    logic        msf, mzf, mof;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] sel(input int r, input int m);
        return {2'b11, 3'(r), 3'(m)};
    endfunction

    task automatic read_reg(input int r, output logic [31:0] v);
        rd_sel = 3'(r);
        #1 v = rd_value;
    endtask

    task automatic check_all_regs(input string req);
        logic [31:0] v;
        for (int r = 0; r < 8; r++) begin
            read_reg(r, v);
            chk(req, v, mreg[r]);
        end
    endtask

    task automatic do_reset();
        in_valid = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int r = 0; r < 8; r++) mreg[r] = 32'h0;
        {msf, mzf, mof} = 3'b000;
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    // bench model of one legal instruction
    task automatic model(input logic [7:0] op, input logic [7:0] mr,
                         output int d, output int s, output string tag);
        logic [31:0] a, b, r;
        logic upd;
        logic ov;
        upd = 1'b1;
        ov  = 1'b0;
        if (op[7:4] == 4'h4) begin
            d = int'(op[2:0]); s = d; a = mreg[d];
            tag = "R7";
            if (op[3]) begin r = a - 1; ov = (a == 32'h8000_0000); end
            else       begin r = a + 1; ov = (a == 32'h7fff_ffff); end
            mreg[d] = r;
        end else begin
            d = int'(mr[2:0]); s = int'(mr[5:3]);
            a = mreg[d]; b = mreg[s];
            r = 32'h0;
            case (op)
                8'h01: begin r = a + b; ov = (a[31] == b[31]) && (r[31] != a[31]); mreg[d] = r; tag = "R3"; end
                8'h29: begin r = a - b; ov = (a[31] != b[31]) && (r[31] != a[31]); mreg[d] = r; tag = "R3"; end
                8'h39: begin r = a - b; ov = (a[31] != b[31]) && (r[31] != a[31]); tag = "R6"; end
                8'h21: begin r = a & b; mreg[d] = r; tag = "R4"; end
                8'h09: begin r = a | b; mreg[d] = r; tag = "R4"; end
                8'h31: begin r = a ^ b; mreg[d] = r; tag = "R4"; end
                8'h89: begin upd = 1'b0; mreg[d] = b; tag = "R5"; end
                8'h87: begin upd = 1'b0; mreg[d] = b; mreg[s] = a; tag = "R5"; end
                8'hF7: begin r = ~a; mreg[d] = r; tag = "R9"; end
                default: begin
                    tag = "R8";
                    if (mr[5:3] == 3'd0) begin r = a + 1; ov = (a == 32'h7fff_ffff); end
                    else                 begin r = a - 1; ov = (a == 32'h8000_0000); end
                    mreg[d] = r;
                end
            endcase
        end
        if (upd) begin
            msf = r[31];
            mzf = (r == 32'h0);
            mof = ov;
        end
    endtask

    task automatic run(input logic [7:0] op, input logic [7:0] mr);
        int d, s;
        string tag;
        logic [31:0] v;
        send(op);
        if (op[7:4] != 4'h4) send(mr);
        @(negedge clk);
        chk("R11 busy after last byte", {31'h0, in_ready}, 32'h0);
        @(negedge clk);
        chk("R11 retire pulse", {30'h0, retire, in_ready}, 32'h3);
        model(op, mr, d, s, tag);
        chk({tag, " flags"}, {29'h0, flag_sf, flag_zf, flag_of}, {29'h0, msf, mzf, mof});
        read_reg(d, v);
        chk({tag, " destination"}, v, mreg[d]);
        read_reg(s, v);
        chk({tag, " R12 source read"}, v, mreg[s]);
    endtask

    // build any value: clear, then double and increment per set bit
    task automatic load(input int r, input logic [31:0] val);
        bit started;
        started = 1'b0;
        run(8'h31, sel(r, r));
        for (int i = 31; i >= 0; i--) begin
            if (started) run(8'h01, sel(r, r));
            if (val[i]) begin
                run(8'h40 | 8'(r), 8'h00);
                started = 1'b1;
            end
        end
    endtask

    task automatic expect_illegal(input logic [7:0] op, input logic [7:0] mr,
                                  input bit two, input string what);
        load(0, 32'h1234_5678);
        load(5, 32'h8000_0001);
        send(op);
        if (two) send(mr);
        @(negedge clk);
        @(negedge clk);
        chk({"R10 illegal set ", what}, {30'h0, illegal, in_ready}, 32'h2);
        chk({"R10 flags kept ", what}, {29'h0, flag_sf, flag_zf, flag_of}, {29'h0, msf, mzf, mof});
        check_all_regs({"R10 regs kept ", what});
        repeat (5) @(negedge clk);
        chk({"R10 still halted ", what}, {30'h0, illegal, in_ready}, 32'h2);
        do_reset();
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        int seed_init;
        seed_init = $urandom(32'd20240611);
        do_reset();
        @(negedge clk);
        // R1 reset state
        chk("R1 ready/illegal", {30'h0, in_ready, illegal}, 32'h2);
        chk("R1 flags", {29'h0, flag_sf, flag_zf, flag_of}, 32'h0);
        check_all_regs("R1 regs zero");

        // R4 worked example and R2 field decode (src reg 3 into dst reg 0)
        load(0, 32'h0a0b_0c0d);
        load(3, 32'haabb_c0d0);
        run(8'h31, 8'hD8);
        chk("R4 xor example", mreg[0], 32'ha0b0_ccdd);
        // R3 add, overflow boundaries
        load(1, 32'h7fff_ffff);
        load(2, 32'h0000_0001);
        run(8'h01, sel(2, 1));
        chk("R3 add overflow OF", {31'h0, flag_of}, 32'h1);
        load(1, 32'h8000_0000);
        run(8'h29, sel(2, 1));
        chk("R3 sub overflow OF", {31'h0, flag_of}, 32'h1);
        // R6 compare: equal, lesser, greater
        load(4, 32'h0a0b_0c0d);
        load(6, 32'h0a0b_0c0d);
        run(8'h39, sel(6, 4));
        chk("R6 equal ZF", {31'h0, flag_zf}, 32'h1);
        load(4, 32'h0a0b_0c07);
        run(8'h39, sel(6, 4));
        chk("R6 lesser SF", {31'h0, flag_sf}, 32'h1);
        run(8'h39, sel(4, 6));
        chk("R6 greater flags", {29'h0, flag_sf, flag_zf, flag_of}, 32'h0);
        // R7 short forms at boundaries
        load(7, 32'h7fff_ffff);
        run(8'h47, 8'h00);
        chk("R7 inc overflow", {29'h0, flag_sf, flag_zf, flag_of}, 32'h5);
        run(8'h4F, 8'h00);
        chk("R7 dec overflow", {29'h0, flag_sf, flag_zf, flag_of}, 32'h1);
        // R8 group inc/dec
        load(5, 32'hffff_ffff);
        run(8'hFF, sel(0, 5));
        chk("R8 inc wrap ZF", {29'h0, flag_sf, flag_zf, flag_of}, 32'h2);
        run(8'hFF, sel(1, 5));
        chk("R8 dec value", mreg[5], 32'hffff_ffff);
        // R9 not
        load(3, 32'h0f0f_00ff);
        run(8'hF7, sel(2, 3));
        chk("R9 not value", mreg[3], 32'hf0f0_ff00);
        // R5 copy and exchange keep flags
        run(8'h89, sel(3, 1));
        run(8'h87, sel(1, 7));
        run(8'h87, sel(2, 2));
        check_all_regs("R5 after copy/exchange");

        // random mix
        for (int k = 0; k < 70; k++) begin
            load(int'($urandom_range(0, 7)), $urandom);
            load(int'($urandom_range(0, 7)), ($urandom_range(0, 3) == 0) ? 32'h8000_0000 : $urandom);
            for (int j = 0; j < 6; j++) begin
                int pick, rg, rm;
                logic [7:0] ops [12];
                ops = '{8'h01, 8'h29, 8'h21, 8'h09, 8'h31, 8'h89,
                        8'h87, 8'h39, 8'h40, 8'h48, 8'hFF, 8'hF7};
                pick = int'($urandom_range(0, 11));
                rg = int'($urandom_range(0, 7));
                rm = int'($urandom_range(0, 7));
                if (pick == 8 || pick == 9)  run(ops[pick] | 8'(rm), 8'h00);
                else if (pick == 10)          run(8'hFF, sel(int'($urandom_range(0, 1)), rm));
                else if (pick == 11)          run(8'hF7, sel(2, rm));
                else                          run(ops[pick], sel(rg, rm));
            end
            check_all_regs("R2 random register state");
        end

        // R10 illegal encodings
        expect_illegal(8'h0F, 8'h00, 1'b0, "unknown opcode");
        expect_illegal(8'h01, 8'h18, 1'b1, "mode not 3");
        expect_illegal(8'hF7, sel(3, 1), 1'b1, "F7 subop 3");
        expect_illegal(8'hFF, sel(2, 1), 1'b1, "FF subop 2");
        @(negedge clk);
        chk("R1 reset clears illegal", {30'h0, in_ready, illegal}, 32'h2);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule